// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This peripheral keeps a 32-bit count of elapsed seconds. A prescaler divides the system clock down to a one-second tick. Software reaches the block through a 4 KB register window on a simple APB-style port with 32-bit little-endian data. A single interrupt request line reports when the count reaches a programmed alarm value.

Software can preset the count through a load register and set an alarm compare value. It manages the interrupt through a one-bit mask, a raw flag, a masked flag and a write-any-value clear. The control register cannot stop the counter. A fixed block of identification bytes sits at the top of the window. Reads return data combinationally from `paddr`, so there are no wait states.

A small bus-phase state machine decides when a write takes effect. It has three states:
- `BUS_IDLE`: no transfer is in progress.
- `BUS_SETUP`: the setup phase of a transfer has been seen.
- `BUS_ACCESS`: the access phase of a transfer has been seen.

Its transitions are:
- IDLE→SETUP when `psel` is high and `penable` is low.
- SETUP→ACCESS when `psel` and `penable` are both high. This is the commit edge for a write.
- SETUP→IDLE when `psel` drops.
- SETUP stays in SETUP while `psel` is high and `penable` is low.
- ACCESS→SETUP when a back-to-back setup phase follows.
- ACCESS→IDLE otherwise.

Top module: `secs_rtc`

## Requirements
- R1: After reset the seconds count, alarm value, load value, mask bit and raw flag are all zero, and `irq` is low.
- R2: The seconds count (read at offset 0x00) rises by exactly one every CLKS_PER_SEC system clock cycles. It wraps from 0xFFFFFFFF to 0.
- R3: A write to the load register (offset 0x08) has three effects. The register reads back the written value. The count is replaced by the written value. The prescaler restarts, so the first increment comes CLKS_PER_SEC cycles after the write.
- R4: The alarm register (offset 0x04) reads back the last value written.
- R5: A write to the mask register (offset 0x10) keeps only bit 0. Reading the mask returns that bit in bit 0, with zeros above it.
- R6: The raw flag (offset 0x14, bit 0) is set on the tick whose new count equals the alarm value. The masked flag (offset 0x18, bit 0) reads raw AND mask, and `irq` is that same level.
- R7: Any write to the clear register (offset 0x1C) clears the raw flag. When a set and a clear fall on the same edge, the set wins.
- R8: The control register (offset 0x0C) always reads 1. Writes to it are ignored, and counting continues.
- R9: Offsets 0xFE0 to 0xFFC return one identification byte per word, in bits 7:0. Word index (offset−0xFE0)>>2 gives, for indices 0 to 7, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1.
- R10: The following read as 0: offsets 0x020 to 0xFDC, the clear register, and any offset whose low two bits are nonzero. Writes to the data, status, identification and reserved offsets change nothing.
- R11: A write takes effect only at the clock edge that ends an access phase, that is with `psel`, `penable` and `pwrite` high after a setup cycle. A setup phase that is abandoned without an access phase changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also drives the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | High for a write, low for a read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the current `paddr` |
| irq | output | 1 | Level interrupt: raw flag AND mask |

## Verification
The alarm tick that sets the raw flag can fall on the same edge as a software write to the clear register.

The bench provokes this collision by loading the count one below the alarm value. It then starts a clear write so that its commit edge is exactly the tenth cycle after the load, which is the edge on which the prescaler rolls over.

The result is judged at the ports. The raw flag must read 1 and `irq` must stay high after that write. A second clear, with no tick on its edge, must then bring both to 0.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_SETUP,
        BUS_ACCESS
    } bus_state_e;

    localparam logic [11:0] OFF_DATA  = 12'h000;
    localparam logic [11:0] OFF_ALARM = 12'h004;
    localparam logic [11:0] OFF_LOAD  = 12'h008;
    localparam logic [11:0] OFF_CTRL  = 12'h00C;
    localparam logic [11:0] OFF_MASK  = 12'h010;
    localparam logic [11:0] OFF_RAW   = 12'h014;
    localparam logic [11:0] OFF_MSTAT = 12'h018;
    localparam logic [11:0] OFF_CLEAR = 12'h01C;
    localparam logic [6:0]  ID_BLOCK  = 7'h7F;  // 0xFE0..0xFFF

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            3'd7: b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/secs_rtc_bus.sv
module secs_rtc_bus
    import secs_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (psel && !penable) state_d = BUS_SETUP;
            BUS_SETUP:  if (!psel) state_d = BUS_IDLE;
                        else if (penable) state_d = BUS_ACCESS;
            BUS_ACCESS: state_d = (psel && !penable) ? BUS_SETUP : BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_stb = 1'b0;
        unique case (state_q)
            BUS_SETUP: wr_stb = psel && penable && pwrite;
            default:   wr_stb = 1'b0;
        endcase
    end

    // R11
    wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(psel && !penable));

endmodule

// File: rtl/secs_rtc_count.sv
module secs_rtc_count #(
    parameter int CLKS_PER_SEC = 50_000_000,
    parameter int CW           = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic [CW-1:0] next_count,
    output logic          tick
);

    localparam int PW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_SEC - 1);

    logic [PW-1:0] pre_q;

    assign next_count = count + 1'b1;
    assign tick       = (pre_q == PRE_LAST) && !load_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            count <= '0;
        end else if (load_en) begin
            pre_q <= '0;
            count <= load_val;
        end else if (tick) begin
            pre_q <= '0;
            count <= next_count;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(count));

endmodule

// File: rtl/secs_rtc_int.sv
module secs_rtc_int (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic mask_wr,
    input  logic mask_val,
    output logic raw,
    output logic mask,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw  <= 1'b0;
            mask <= 1'b0;
        end else begin
            if (set)      raw <= 1'b1;
            else if (clr) raw <= 1'b0;
            if (mask_wr)  mask <= mask_val;
        end
    end

    assign irq = raw & mask;

    // R7
    set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> raw);

    // R7
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !raw);

    // R6
    raw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(set));

endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import secs_rtc_pkg::*;
#(
    parameter int CLKS_PER_SEC = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        irq
);

    localparam int DW = 32;

    logic          wr_stb;
    logic          aligned;
    logic [DW-1:0] alarm_q, load_q, count, next_count;
    logic          tick, raw, mask;
    logic          wr_alarm, wr_load, wr_mask, wr_clear;

    assign aligned  = (paddr[1:0] == 2'b00);
    assign wr_alarm = wr_stb && aligned && (paddr[11:2] == OFF_ALARM[11:2]);
    assign wr_load  = wr_stb && aligned && (paddr[11:2] == OFF_LOAD[11:2]);
    assign wr_mask  = wr_stb && aligned && (paddr[11:2] == OFF_MASK[11:2]);
    assign wr_clear = wr_stb && aligned && (paddr[11:2] == OFF_CLEAR[11:2]);

    secs_rtc_bus u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb)
    );

    secs_rtc_count #(.CLKS_PER_SEC(CLKS_PER_SEC), .CW(DW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (wr_load),
        .load_val   (pwdata),
        .count      (count),
        .next_count (next_count),
        .tick       (tick)
    );

    secs_rtc_int u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (tick && (next_count == alarm_q)),
        .clr      (wr_clear),
        .mask_wr  (wr_mask),
        .mask_val (pwdata[0]),
        .raw      (raw),
        .mask     (mask),
        .irq      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
            load_q  <= '0;
        end else begin
            if (wr_alarm) alarm_q <= pwdata;
            if (wr_load)  load_q  <= pwdata;
        end
    end

    always_comb begin
        prdata = '0;
        if (aligned) begin
            if (paddr[11:5] == ID_BLOCK) begin
                prdata = {24'h0, id_byte(paddr[4:2])};
            end else begin
                unique case (paddr)
                    OFF_DATA:  prdata = count;
                    OFF_ALARM: prdata = alarm_q;
                    OFF_LOAD:  prdata = load_q;
                    OFF_CTRL:  prdata = 32'd1;
                    OFF_MASK:  prdata = {31'h0, mask};
                    OFF_RAW:   prdata = {31'h0, raw};
                    OFF_MSTAT: prdata = {31'h0, raw & mask};
                    default:   prdata = '0;
                endcase
            end
        end
    end

    // R3
    load_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (count == $past(pwdata)) && (load_q == $past(pwdata)));

    // R4
    alarm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_alarm |=> $stable(alarm_q));

endmodule

// File: tb/secs_rtc_tb.sv
module secs_rtc_tb;

    localparam int CPS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    secs_rtc #(.CLKS_PER_SEC(CPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h004, 32'h12345678, 32'h0,        4'd4},  // R4
        '{1'b0, 12'h004, 32'h0,        32'h12345678, 4'd4},
        '{1'b1, 12'h010, 32'hFFFFFFFF, 32'h0,        4'd5},  // R5
        '{1'b0, 12'h010, 32'h0,        32'h1,        4'd5},
        '{1'b1, 12'h010, 32'hFFFFFFFE, 32'h0,        4'd5},
        '{1'b0, 12'h010, 32'h0,        32'h0,        4'd5},
        '{1'b1, 12'h00C, 32'h0,        32'h0,        4'd8},  // R8
        '{1'b0, 12'h00C, 32'h0,        32'h1,        4'd8},
        '{1'b0, 12'hFE0, 32'h0,        32'h31,       4'd9},  // R9
        '{1'b0, 12'hFE4, 32'h0,        32'h10,       4'd9},
        '{1'b0, 12'hFE8, 32'h0,        32'h14,       4'd9},
        '{1'b0, 12'hFEC, 32'h0,        32'h00,       4'd9},
        '{1'b0, 12'hFF0, 32'h0,        32'h0D,       4'd9},
        '{1'b0, 12'hFF4, 32'h0,        32'hF0,       4'd9},
        '{1'b0, 12'hFF8, 32'h0,        32'h05,       4'd9},
        '{1'b0, 12'hFFC, 32'h0,        32'hB1,       4'd9},
        '{1'b1, 12'hFE0, 32'hFF,       32'h0,        4'd10}, // R10
        '{1'b0, 12'hFE0, 32'h0,        32'h31,       4'd10},
        '{1'b0, 12'h020, 32'h0,        32'h0,        4'd10},
        '{1'b0, 12'hFDC, 32'h0,        32'h0,        4'd10},
        '{1'b0, 12'h01C, 32'h0,        32'h0,        4'd10},
        '{1'b0, 12'h006, 32'h0,        32'h0,        4'd10},
        '{1'b1, 12'h014, 32'h1,        32'h0,        4'd10},
        '{1'b0, 12'h014, 32'h0,        32'h0,        4'd10},
        '{1'b1, 12'h008, 32'hCAFE0000, 32'h0,        4'd3}   // R3
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Caller is at a negedge; the write commits on the second posedge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // Combinational read within one low half-cycle; no edge is crossed.
    task automatic peek(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        peek(a, v);
        chk(v, exp, tag);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(12'h000, 32'h0, "R1 count");
        rd_chk(12'h004, 32'h0, "R1 alarm");
        rd_chk(12'h008, 32'h0, "R1 load");
        rd_chk(12'h010, 32'h0, "R1 mask");
        rd_chk(12'h014, 32'h0, "R1 raw");
        chk({31'h0, irq}, 32'h0, "R1 irq");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else rd_chk(VEC[i].addr, VEC[i].exp, $sformatf("R%0d vec %0d", VEC[i].req, i));
        end
        rd_chk(12'h008, 32'hCAFE0000, "R3 load readback");

        // R3 / R2: count replaced, prescaler restarted
        wr(12'h008, 32'd100);
        rd_chk(12'h000, 32'd100, "R3 count loaded");
        repeat (9) @(negedge clk);
        rd_chk(12'h000, 32'd100, "R3 no tick before period");
        @(negedge clk);
        rd_chk(12'h000, 32'd101, "R2 first tick");
        repeat (10) @(negedge clk);
        rd_chk(12'h000, 32'd102, "R2 second tick");
        repeat (30) @(negedge clk);
        rd_chk(12'h000, 32'd105, "R2 R8 counting continues");

        // R2 wrap
        wr(12'h008, 32'hFFFFFFFF);
        repeat (10) @(negedge clk);
        rd_chk(12'h000, 32'h0, "R2 wrap");

        // R10 data write ignored
        wr(12'h008, 32'd500);
        wr(12'h000, 32'd7);
        rd_chk(12'h000, 32'd500, "R10 data write ignored");

        // R6 alarm sets raw, irq follows mask
        wr(12'h010, 32'h1);
        wr(12'h004, 32'd201);
        wr(12'h01C, 32'h0);
        wr(12'h008, 32'd200);
        rd_chk(12'h014, 32'h0, "R6 raw before alarm");
        repeat (9) @(negedge clk);
        chk({31'h0, irq}, 32'h0, "R6 irq before alarm");
        @(negedge clk);
        chk({31'h0, irq}, 32'h1, "R6 irq on alarm");
        rd_chk(12'h014, 32'h1, "R6 raw on alarm");
        rd_chk(12'h018, 32'h1, "R6 masked on alarm");
        wr(12'h010, 32'h0);
        rd_chk(12'h018, 32'h0, "R6 masked when mask off");
        rd_chk(12'h014, 32'h1, "R6 raw when mask off");
        chk({31'h0, irq}, 32'h0, "R6 irq when mask off");
        wr(12'h010, 32'h1);
        chk({31'h0, irq}, 32'h1, "R6 irq when mask back");
        wr(12'h01C, 32'hDEADBEEF);
        rd_chk(12'h014, 32'h0, "R7 clear");
        chk({31'h0, irq}, 32'h0, "R7 irq after clear");

        // R7 set and clear on same edge
        wr(12'h004, 32'd301);
        wr(12'h008, 32'd300);
        repeat (8) @(negedge clk);
        wr(12'h01C, 32'h0);
        rd_chk(12'h014, 32'h1, "R7 set wins over clear");
        chk({31'h0, irq}, 32'h1, "R7 irq after collision");
        wr(12'h01C, 32'h0);
        rd_chk(12'h014, 32'h0, "R7 later clear");

        // R11 abandoned setup phase
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h008; pwdata = 32'h55;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        rd_chk(12'h008, 32'd300, "R11 setup-only no write");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule